// File: doc/BRIEF.md
# Peripheral Bus Address Decoder

This block is one slice of an on-chip interconnect. On one side it takes a 32-bit APB-style request from the processor side. On the other side it drives a set of peripheral slots. The base address of each slot is a design-time parameter. Each slot owns one naturally aligned 4 KiB window. The decoder compares the upper address bits with every base and raises the select of the one slot that matches. A slot only ever sees the word offset inside its own window. Two slots can therefore hold the same peripheral design at different bases and answer to identical offsets.

For the access phase, the decoder records which slot was hit during the setup phase. It returns the ready and read data of that slot only. Read data from the slot side is narrower than the bus and is widened with zeros. Write data is cut down to the slot width. When an address lies in no window, no slot is touched. That access completes at once, with an error flag and zero read data.

Top module: `periph_addr_decoder`

## Requirements
- R1: When psel is high and paddr[31:12] equals bits [31:12] of the base of slot i, bit i of slot_sel is high in both the setup cycle and the access cycles, and slot_sel does not change from the setup cycle to the access phase.
- R2: slot_addr always equals paddr[11:2]. Byte-lane bits paddr[1:0] never reach a slot.
- R3: Two slots with different bases give the same slot_addr for the same in-window offset. For example, 0x40005008 and 0x40006008 both give slot_addr 2, but they select different slots.
- R4: At most one slot_sel bit is ever high. If two slots share a base, the slot with the lower index wins, and the other slot is never selected.
- R5: In the access phase of a mapped transfer, pready equals the slot_ready bit of the selected slot. prdata equals that slot's slot_rdata. The ready and data lines of every other slot have no effect.
- R6: Slot read data is SLOT_DW bits wide (16 in the default build) and sits at bits [i*SLOT_DW +: SLOT_DW] of slot_rdata. On prdata it appears in the low bits, and all bits above it read zero.
- R7: slot_wdata equals pwdata[SLOT_DW-1:0]. slot_write follows pwrite. slot_enable is high only in the access phase of a mapped transfer.
- R8: An access to an address outside every window asserts no slot_sel and no slot_enable. It gives pready=1, pslverr=1 and prdata=0 in its first access cycle.
- R9: While the selected slot holds its ready low, pready stays low and pslverr stays low, for any number of wait cycles.
- R10: Outside the access phase (psel low, or the setup cycle), pready, pslverr, prdata and slot_enable are all zero. With psel low, slot_sel is zero.
- R11: While presetn is low, and in the first cycle after it, the decoder selects no slot with the bus idle and drives pready, pslverr and prdata to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Transfer request from the processor side |
| penable | input | 1 | Access-phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 32 | Full byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, zero-extended from the selected slot |
| pready | output | 1 | Transfer completes this cycle |
| pslverr | output | 1 | Unmapped-address error |
| slot_sel | output | N_SLOTS | One select per slot |
| slot_enable | output | 1 | Access phase of a mapped transfer |
| slot_write | output | 1 | Direction forwarded to slots |
| slot_addr | output | REGION_LOG2-2 | Word offset inside the window (paddr[11:2]) |
| slot_wdata | output | SLOT_DW | Truncated write data, shared by all slots |
| slot_rdata | input | N_SLOTS*SLOT_DW | Packed read data of all slots |
| slot_ready | input | N_SLOTS | Per-slot ready |

## Verification
The bench builds the decoder with five slots of 16-bit data. The bases are 0x40004000, 0x40005000, 0x40006000 and 0x40008000, and the fifth slot repeats 0x40006000. The repeated base makes the lower-index rule observable. The hole at 0x40007000 and the space below 0x40004000 give unmapped addresses right next to mapped windows. A 16-bit slot width means that the truncation of write data and the zero-filling of read data both show on real bits.

// File: rtl/pdec_pkg.sv
package pdec_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACCESS = 2'd2
    } apb_phase_e;

    function automatic apb_phase_e phase_of(input logic sel, input logic en);
        if (!sel)     return PH_IDLE;
        else if (!en) return PH_SETUP;
        else          return PH_ACCESS;
    endfunction

endpackage

// File: rtl/pdec_match.sv
module pdec_match #(
    parameter int N_SLOTS     = 4,
    parameter int REGION_LOG2 = 12,
    parameter logic [N_SLOTS*32-1:0] SLOT_BASES = '0
) (
    input  logic [31-REGION_LOG2:0] page,
    output logic [N_SLOTS-1:0]      hit_vec
);
    localparam int PW = 32 - REGION_LOG2;

    for (genvar i = 0; i < N_SLOTS; i++) begin : g_cmp
        localparam logic [PW-1:0] PAGE_I = SLOT_BASES[i*32+REGION_LOG2 +: PW];
        assign hit_vec[i] = (page == PAGE_I);
    end
endmodule

// File: rtl/pdec_pick.sv
module pdec_pick #(
    parameter int N_SLOTS = 4,
    parameter int IW      = 2
) (
    input  logic [N_SLOTS-1:0] hit_vec,
    output logic               any_hit,
    output logic [IW-1:0]      win_idx
);
    always_comb begin
        any_hit = 1'b0;
        win_idx = '0;
        for (int i = N_SLOTS - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                any_hit = 1'b1;
                win_idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/pdec_resp.sv
module pdec_resp #(
    parameter int N_SLOTS = 4,
    parameter int SLOT_DW = 16,
    parameter int IW      = 2
) (
    input  logic                       pclk,
    input  logic                       presetn,
    input  logic                       access,
    input  logic                       hit,
    input  logic [IW-1:0]              idx,
    input  logic [N_SLOTS*SLOT_DW-1:0] slot_rdata,
    input  logic [N_SLOTS-1:0]         slot_ready,
    output logic [31:0]                prdata,
    output logic                       pready,
    output logic                       pslverr
);
    logic [SLOT_DW-1:0] rd_pick;

    always_comb begin
        rd_pick = slot_rdata[int'(idx)*SLOT_DW +: SLOT_DW];
        prdata  = '0;
        pready  = 1'b0;
        pslverr = 1'b0;
        if (access) begin
            if (hit) begin
                prdata[SLOT_DW-1:0] = rd_pick;
                pready              = slot_ready[idx];
            end else begin
                pready  = 1'b1;
                pslverr = 1'b1;
            end
        end
    end

    // R9: a stalled mapped transfer never reports an error
    a_r9_wait_no_err: assert property (@(posedge pclk) disable iff (!presetn)
        (access && hit && !slot_ready[idx]) |-> (!pready && !pslverr));

    // R6: bits above the slot width stay clear
    a_r6_zero_ext: assert property (@(posedge pclk) disable iff (!presetn)
        (prdata >> SLOT_DW) == 32'd0);
endmodule

// File: rtl/periph_addr_decoder.sv
module periph_addr_decoder
    import pdec_pkg::*;
#(
    parameter int N_SLOTS     = 4,
    parameter int SLOT_DW     = 16,
    parameter int REGION_LOG2 = 12,
    parameter logic [N_SLOTS*32-1:0] SLOT_BASES =
        {32'h4000_8000, 32'h4000_6000, 32'h4000_5000, 32'h4000_4000}
) (
    input  logic                         pclk,
    input  logic                         presetn,
    input  logic                         psel,
    input  logic                         penable,
    input  logic                         pwrite,
    input  logic [31:0]                  paddr,
    input  logic [31:0]                  pwdata,
    output logic [31:0]                  prdata,
    output logic                         pready,
    output logic                         pslverr,
    output logic [N_SLOTS-1:0]           slot_sel,
    output logic                         slot_enable,
    output logic                         slot_write,
    output logic [REGION_LOG2-3:0]       slot_addr,
    output logic [SLOT_DW-1:0]           slot_wdata,
    input  logic [N_SLOTS*SLOT_DW-1:0]   slot_rdata,
    input  logic [N_SLOTS-1:0]           slot_ready
);
    localparam int IW = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;

    typedef struct packed {
        logic          hit;
        logic [IW-1:0] idx;
    } dec_t;

    dec_t          st_d, st_q;
    apb_phase_e    ph;
    logic [N_SLOTS-1:0] hit_vec;
    logic          live_any;
    logic [IW-1:0] live_idx;
    logic          acc;

    assign ph  = phase_of(psel, penable);
    assign acc = (ph == PH_ACCESS);

    pdec_match #(
        .N_SLOTS(N_SLOTS), .REGION_LOG2(REGION_LOG2), .SLOT_BASES(SLOT_BASES)
    ) u_match (
        .page    (paddr[31:REGION_LOG2]),
        .hit_vec (hit_vec)
    );

    pdec_pick #(.N_SLOTS(N_SLOTS), .IW(IW)) u_pick (
        .hit_vec (hit_vec),
        .any_hit (live_any),
        .win_idx (live_idx)
    );

    // next-state: capture the decode at the setup cycle, hold through access
    always_comb begin
        st_d = st_q;
        if (ph == PH_SETUP) begin
            st_d.hit = live_any;
            st_d.idx = live_idx;
        end
    end

    always_ff @(posedge pclk) begin
        if (!presetn) st_q <= '0;
        else          st_q <= st_d;
    end

    always_comb begin
        slot_sel = '0;
        if (ph == PH_SETUP && live_any)   slot_sel[live_idx] = 1'b1;
        else if (acc && st_q.hit)         slot_sel[st_q.idx] = 1'b1;
    end

    assign slot_enable = acc && st_q.hit;
    assign slot_write  = pwrite;
    assign slot_addr   = paddr[REGION_LOG2-1:2];
    assign slot_wdata  = pwdata[SLOT_DW-1:0];

    pdec_resp #(.N_SLOTS(N_SLOTS), .SLOT_DW(SLOT_DW), .IW(IW)) u_resp (
        .pclk       (pclk),
        .presetn    (presetn),
        .access     (acc),
        .hit        (st_q.hit),
        .idx        (st_q.idx),
        .slot_rdata (slot_rdata),
        .slot_ready (slot_ready),
        .prdata     (prdata),
        .pready     (pready),
        .pslverr    (pslverr)
    );

    logic unused_lo;
    if (SLOT_DW < 32) begin : g_unused_hi
        assign unused_lo = ^{paddr[1:0], pwdata[31:SLOT_DW]};
    end else begin : g_unused_nohi
        assign unused_lo = ^paddr[1:0];
    end

    // R4: never more than one slot selected
    a_r4_onehot_sel: assert property (@(posedge pclk) disable iff (!presetn)
        $onehot0(slot_sel));

    // R1: the select chosen at setup is the one held in the access phase
    a_r1_sel_hold: assert property (@(posedge pclk) disable iff (!presetn)
        (acc && $past(psel && !penable)) |-> (slot_sel == $past(slot_sel)));

    // R8: an error completion touches no slot and returns zero
    a_r8_err_clean: assert property (@(posedge pclk) disable iff (!presetn)
        (acc && pslverr) |-> (pready && slot_sel == '0 && !slot_enable && prdata == 32'd0));

    // R10: no response outside the access phase
    a_r10_quiet: assert property (@(posedge pclk) disable iff (!presetn)
        !acc |-> (!pready && !pslverr && !slot_enable));

    // R5: completion follows the ready of the selected slot
    a_r5_ready_src: assert property (@(posedge pclk) disable iff (!presetn)
        (acc && slot_sel != '0) |-> (pready == |(slot_sel & slot_ready)));
endmodule

// File: tb/sim_periph_addr_decoder.sv
module sim_periph_addr_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 5;
    localparam int DW = 16;
    localparam int WATCHDOG = 20000;
    localparam logic [NS*32-1:0] BASES =
        {32'h4000_6000, 32'h4000_8000, 32'h4000_6000, 32'h4000_5000, 32'h4000_4000};

    logic clk = 1'b0;
    logic presetn = 1'b0;
    logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [31:0] paddr = '0, pwdata = '0;
    logic [31:0] prdata;
    logic pready, pslverr;
    logic [NS-1:0] slot_sel;
    logic slot_enable, slot_write;
    logic [9:0] slot_addr;
    logic [DW-1:0] slot_wdata;
    logic [NS*DW-1:0] slot_rdata = '0;
    logic [NS-1:0] slot_ready = '0;

    int checks = 0, errors = 0, cyc = 0;
    bit running = 0, done = 0;
    int tx = 0;

    logic [NS-1:0] last_sel;
    logic [9:0]    last_addr;
    logic [31:0]   last_rdata;
    logic          last_err;
    logic [DW-1:0] last_wdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    periph_addr_decoder #(
        .N_SLOTS(NS), .SLOT_DW(DW), .REGION_LOG2(12), .SLOT_BASES(BASES)
    ) u0 (
        .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .slot_sel(slot_sel),
        .slot_enable(slot_enable), .slot_write(slot_write), .slot_addr(slot_addr),
        .slot_wdata(slot_wdata), .slot_rdata(slot_rdata), .slot_ready(slot_ready)
    );

    function automatic int ref_slot(input logic [31:0] a);
        for (int i = 0; i < NS; i++)
            if (a[31:12] == BASES[i*32+12 +: 20]) return i;
        return -1;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // per-cycle reference comparison
    always @(negedge clk) begin
        if (running) begin
            int s;
            logic acc;
            logic [NS-1:0] e_sel;
            logic [31:0] e_rd;
            logic e_rdy;
            s   = ref_slot(paddr);
            acc = psel && penable;
            e_sel = (psel && s >= 0) ? (NS'(1) << s) : '0;
            e_rdy = acc ? ((s >= 0) ? slot_ready[s] : 1'b1) : 1'b0;
            e_rd  = (acc && s >= 0) ? {16'h0, slot_rdata[s*DW +: DW]} : 32'h0;
            chk("R1 slot_sel", 32'(slot_sel), 32'(e_sel));
            chk("R2 slot_addr", 32'(slot_addr), 32'(paddr[11:2]));
            chk("R7 slot_wdata", 32'(slot_wdata), 32'(pwdata[15:0]));
            chk("R7 slot_write", 32'(slot_write), 32'(pwrite));
            chk("R7 slot_enable", 32'(slot_enable), 32'(acc && s >= 0));
            chk("R5 pready", 32'(pready), 32'(e_rdy));
            chk("R8 pslverr", 32'(pslverr), 32'(acc && s < 0));
            chk("R5 prdata", prdata, e_rd);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WATCHDOG);
            summary();
        end
    end

    task automatic xfer(input logic [31:0] a, input logic wr, input logic [31:0] wd,
                        input int waits);
        int s;
        s = ref_slot(a);
        tx++;
        for (int i = 0; i < NS; i++)
            slot_rdata[i*DW +: DW] = 16'(16'h1000 * (i + 1) + tx * 7 + 16'hF000);
        @(posedge clk); #1;
        psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = wd;
        slot_ready = '1;
        if (s >= 0) slot_ready[s] = 1'b0;
        @(posedge clk); #1;
        penable = 1;
        for (int w = 0; w < waits; w++) begin
            @(negedge clk);
            if (s >= 0) chk("R9 stalled pready", 32'(pready), 32'd0);
            @(posedge clk); #1;
        end
        if (s >= 0) slot_ready = NS'(1) << s;
        else slot_ready = '0;
        @(negedge clk);
        last_sel = slot_sel; last_addr = slot_addr; last_rdata = prdata;
        last_err = pslverr; last_wdata = slot_wdata;
        chk("R5 pready done", 32'(pready), 32'd1);
        @(posedge clk); #1;
        psel = 0; penable = 0; slot_ready = '0;
    endtask

    initial begin
        running = 1;
        repeat (3) @(negedge clk);
        chk("R11 reset sel", 32'(slot_sel), 32'd0);
        chk("R11 reset pready", 32'(pready), 32'd0);
        @(posedge clk); #1; presetn = 1;
        @(negedge clk);
        chk("R11 after reset prdata", prdata, 32'd0);
        chk("R10 idle pslverr", 32'(pslverr), 32'd0);

        xfer(32'h4000_5008, 0, 32'h0, 0);
        chk("R3 first instance slot_addr", 32'(last_addr), 32'd2);
        chk("R3 first instance sel", 32'(last_sel), 32'h02);
        xfer(32'h4000_6008, 0, 32'h0, 0);
        chk("R3 second instance slot_addr", 32'(last_addr), 32'd2);
        chk("R4 shadowed duplicate base", 32'(last_sel), 32'h04);
        chk("R6 zero upper bits", last_rdata[31:16], 32'h0);
        xfer(32'h4000_4FFC, 1, 32'hDEAD_BEEF, 2);
        chk("R7 truncated wdata", 32'(last_wdata), 32'h0000_BEEF);
        chk("R2 top word offset", 32'(last_addr), 32'h3FF);
        xfer(32'h4000_8004, 0, 32'h0, 3);
        chk("R9 no error after waits", 32'(last_err), 32'd0);
        xfer(32'h4000_7000, 0, 32'h0, 0);
        chk("R8 hole error", 32'(last_err), 32'd1);
        chk("R8 hole rdata", last_rdata, 32'd0);
        xfer(32'h0000_0008, 1, 32'h1234_5678, 0);
        chk("R8 low error", 32'(last_err), 32'd1);
        xfer(32'h4000_3FFC, 0, 32'h0, 1);
        chk("R8 just below window", 32'(last_sel), 32'd0);
        xfer(32'h4000_4000, 0, 32'h0, 1);
        chk("R1 window start", 32'(last_sel), 32'h01);
        xfer(32'h4000_5FFF, 1, 32'hA5A5_5A5A, 0);
        chk("R2 byte bits dropped", 32'(last_addr), 32'h3FF);
        xfer(32'h4000_6FFC, 0, 32'h0, 4);
        xfer(32'h4000_5000, 0, 32'h0, 0);
        for (int k = 0; k < 12; k++)
            xfer(32'h4000_4000 + 32'(k) * 32'h0000_1000 + 32'(k * 4), k[0], 32'(k * 32'h0101_0101), k % 3);
        repeat (2) @(negedge clk);
        done = 1;
        summary();
    end
endmodule